// File: doc/BRIEF.md
# Software Interrupt Context-Save Sequencer

This block carries out, one memory cycle at a time, the full register-file save that an 8-bit CPU core performs on entry to a software trap and on the mask-then-wait instruction. When the core sees such an instruction, it presents the current register values and pulses `start` together with a two-bit `kind` code. The sequencer sets the entire-state flag in a working copy of the condition codes. It then writes twelve bytes downward on the system stack through a registered byte write port. After that it follows one of two paths. For the three trap kinds it reads a 16-bit handler address from the top memory page through a synchronous read port and hands back a new program counter. For the wait kind it parks in a halted state until an external wake.

The core takes the returned condition codes, stack pointer and program counter when `done` pulses. Decoding the instruction and computing arithmetic results are left to the surrounding core. The sequencer keeps the trap kinds to fixed cycle budgets, so the core sees the same instruction timing on every run.

Top module: `ctx_stack_seq`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `done`, `halted`, `mem_we` and `mem_re` are low and `cc_out`, `s_out`, `pc_out` read zero, until a `start` is accepted.
- R2: A start accepted in cycle 0 produces exactly twelve byte writes in cycles 1 to 12, one per cycle, each at an address one below the previous one, the first at `s_in`-1. Afterwards, addresses `s_in`-12 upward hold CC, A, B, DP, X high, X low, Y high, Y low, U high, U low, PC high, PC low.
- R3: The stacked CC byte is `cc_in` with bit 7 (entire-state flag) set for kinds 0, 1 and 2. For kind 3 it is (`cc_in` AND `mask_imm`) with bit 7 set.
- R4: Kinds 0, 1 and 2 read exactly two bytes, from vector addresses 0xFFFA, 0xFFF4 and 0xFFF2 respectively. The byte at the vector address is the high half and the byte at the next address is the low half. Read data returns on `mem_rdata` in the cycle after `mem_re` with the address. `pc_out` equals the assembled vector when `done` is high.
- R5: After kind 0, `cc_out` equals the stacked CC with bit 6 (fast-interrupt mask) and bit 4 (interrupt mask) also set. After kinds 1 and 2, `cc_out` equals the stacked CC.
- R6: `done` is high for exactly one cycle: in cycle 19 for kind 0 and in cycle 20 for kinds 1 and 2. In that cycle `s_out` equals `s_in`-12.
- R7: Kind 3 performs no read and raises `done` and `halted` in cycle 13. `pc_out` then equals `pc_in` and `cc_out` equals the stacked CC. `halted` stays high until `wake` is sampled high and is low in the following cycle.
- R8: A `start` pulse while `busy` or `halted` is high is ignored: no further write, no extra `done`, and the running sequence keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a context save (accepted only when idle) |
| kind | input | 2 | 0 trap, 1 second trap, 2 third trap, 3 mask-and-wait |
| mask_imm | input | 8 | Immediate ANDed into CC for kind 3 |
| cc_in | input | 8 | Condition codes |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| dp_in | input | 8 | Direct page register |
| x_in | input | 16 | Index register X |
| y_in | input | 16 | Index register Y |
| u_in | input | 16 | User stack pointer |
| s_in | input | 16 | System stack pointer |
| pc_in | input | 16 | Program counter to save |
| wake | input | 1 | Leaves the halted state |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| mem_addr | output | 16 | Memory address, registered |
| mem_we | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte write data |
| mem_re | output | 1 | Byte read strobe |
| cc_out | output | 8 | Updated condition codes |
| s_out | output | 16 | Updated system stack pointer |
| pc_out | output | 16 | New program counter |
| busy | output | 1 | Sequence in progress |
| halted | output | 1 | Waiting for wake after kind 3 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the byte order of the stacked image. A design that swapped the halves of a word, or pushed the 8-bit registers in the wrong order, leaves a memory image that the bench compares byte by byte. It checks the stacked CC under random masks and with the entire-state flag already set or clear. A wrong mask would show up in bit 7 or in the ANDed bits of kind 3. It measures the completion cycle of each kind, which exposes a missing pad cycle or a shared budget between kinds. It also sends start pulses while busy and while halted, where a design that restarted would write extra bytes or pulse done a second time. Stack pointers near address zero and the vector high/low assembly complete the corner cases.

// File: rtl/ctxs_pkg.sv
package ctxs_pkg;

  typedef enum logic [1:0] {
    K_TRAP1 = 2'd0,
    K_TRAP2 = 2'd1,
    K_TRAP3 = 2'd2,
    K_WAIT  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_RDA,
    ST_RDB,
    ST_RDC,
    ST_PAD,
    ST_HALT
  } st_e;

  localparam int CC_ENT  = 7;
  localparam int CC_FMSK = 6;
  localparam int CC_IMSK = 4;
  localparam int NBYTES  = 12;
  localparam int IDX_W   = $clog2(NBYTES + 1);

  typedef struct packed {
    logic [7:0]  cc;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  dp;
    logic [15:0] x;
    logic [15:0] y;
    logic [15:0] u;
    logic [15:0] pc;
  } ctx_t;

endpackage

// File: rtl/ctxs_byte_mux.sv
module ctxs_byte_mux
  import ctxs_pkg::*;
(
  input  ctx_t             ctx,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);
  // Push order: program counter first, condition codes last; low half of a word first.
  always_comb begin
    case (idx)
      IDX_W'(0):  byte_o = ctx.pc[7:0];
      IDX_W'(1):  byte_o = ctx.pc[15:8];
      IDX_W'(2):  byte_o = ctx.u[7:0];
      IDX_W'(3):  byte_o = ctx.u[15:8];
      IDX_W'(4):  byte_o = ctx.y[7:0];
      IDX_W'(5):  byte_o = ctx.y[15:8];
      IDX_W'(6):  byte_o = ctx.x[7:0];
      IDX_W'(7):  byte_o = ctx.x[15:8];
      IDX_W'(8):  byte_o = ctx.dp;
      IDX_W'(9):  byte_o = ctx.b;
      IDX_W'(10): byte_o = ctx.a;
      IDX_W'(11): byte_o = ctx.cc;
      default:    byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/ctxs_vec_sel.sv
module ctxs_vec_sel
  import ctxs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int VEC_TRAP1 = 16'hFFFA,
  parameter int VEC_TRAP2 = 16'hFFF4,
  parameter int VEC_TRAP3 = 16'hFFF2
) (
  input  kind_e         kind,
  output logic [AW-1:0] vec_o
);
  always_comb begin
    case (kind)
      K_TRAP2: vec_o = AW'(VEC_TRAP2);
      K_TRAP3: vec_o = AW'(VEC_TRAP3);
      default: vec_o = AW'(VEC_TRAP1);
    endcase
  end
endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctxs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LAT_TRAP1 = 19,
  parameter int LAT_TRAP2 = 20,
  parameter int VEC_TRAP1 = 16'hFFFA,
  parameter int VEC_TRAP2 = 16'hFFF4,
  parameter int VEC_TRAP3 = 16'hFFF2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic [7:0]    mask_imm,
  input  logic [7:0]    cc_in,
  input  logic [7:0]    a_in,
  input  logic [7:0]    b_in,
  input  logic [7:0]    dp_in,
  input  logic [15:0]   x_in,
  input  logic [15:0]   y_in,
  input  logic [15:0]   u_in,
  input  logic [15:0]   s_in,
  input  logic [15:0]   pc_in,
  input  logic          wake,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          mem_re,
  output logic [7:0]    cc_out,
  output logic [15:0]   s_out,
  output logic [15:0]   pc_out,
  output logic          busy,
  output logic          halted,
  output logic          done
);
  localparam int LAT_MAX = (LAT_TRAP1 > LAT_TRAP2) ? LAT_TRAP1 : LAT_TRAP2;
  localparam int CYC_W   = $clog2(LAT_MAX + 1);
  localparam logic [CYC_W-1:0] END_T1  = CYC_W'(LAT_TRAP1 - 1);
  localparam logic [CYC_W-1:0] END_T23 = CYC_W'(LAT_TRAP2 - 1);
  localparam logic [7:0] MSK_SET = 8'((1 << CC_FMSK) | (1 << CC_IMSK));

  st_e              st;
  kind_e            kind_q;
  ctx_t             ctx_q;
  ctx_t             ctx_next;
  logic [15:0]      sp_q;
  logic [IDX_W-1:0] idx_q;
  logic [CYC_W-1:0] cyc_q;
  logic [7:0]       vhi_q;
  logic [7:0]       vlo_q;
  logic [7:0]       push_byte;
  logic [AW-1:0]    vec_addr;
  logic [7:0]       cc_work;
  logic [CYC_W-1:0] end_cyc;

  // Entire-state flag goes in before anything is stacked; wait kind masks first.
  always_comb begin
    cc_work         = (kind_e'(kind) == K_WAIT) ? (cc_in & mask_imm) : cc_in;
    cc_work[CC_ENT] = 1'b1;
    ctx_next = '{cc: cc_work, a: a_in, b: b_in, dp: dp_in,
                 x: x_in, y: y_in, u: u_in, pc: pc_in};
  end

  assign end_cyc = (kind_q == K_TRAP1) ? END_T1 : END_T23;

  ctxs_byte_mux u_mux (
    .ctx    (ctx_q),
    .idx    (idx_q),
    .byte_o (push_byte)
  );

  ctxs_vec_sel #(
    .AW(AW), .VEC_TRAP1(VEC_TRAP1), .VEC_TRAP2(VEC_TRAP2), .VEC_TRAP3(VEC_TRAP3)
  ) u_vec (
    .kind  (kind_q),
    .vec_o (vec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      kind_q    <= K_TRAP1;
      ctx_q     <= '0;
      sp_q      <= '0;
      idx_q     <= '0;
      cyc_q     <= '0;
      vhi_q     <= '0;
      vlo_q     <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      mem_re    <= 1'b0;
      cc_out    <= '0;
      s_out     <= '0;
      pc_out    <= '0;
      busy      <= 1'b0;
      halted    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      if (busy) cyc_q <= cyc_q + 1'b1;
      case (st)
        ST_IDLE: begin
          if (start) begin
            kind_q    <= kind_e'(kind);
            ctx_q     <= ctx_next;
            sp_q      <= s_in - 16'd1;
            mem_we    <= 1'b1;
            mem_addr  <= AW'(s_in - 16'd1);
            mem_wdata <= pc_in[7:0];
            idx_q     <= IDX_W'(1);
            cyc_q     <= CYC_W'(1);
            busy      <= 1'b1;
            st        <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (idx_q != IDX_W'(NBYTES)) begin
            mem_we    <= 1'b1;
            mem_addr  <= AW'(sp_q - 16'd1);
            mem_wdata <= push_byte;
            sp_q      <= sp_q - 16'd1;
            idx_q     <= idx_q + 1'b1;
          end else if (kind_q == K_WAIT) begin
            halted <= 1'b1;
            done   <= 1'b1;
            busy   <= 1'b0;
            cc_out <= ctx_q.cc;
            s_out  <= sp_q;
            pc_out <= ctx_q.pc;
            st     <= ST_HALT;
          end else begin
            mem_re   <= 1'b1;
            mem_addr <= vec_addr;
            st       <= ST_RDA;
          end
        end
        ST_RDA: begin
          mem_re   <= 1'b1;
          mem_addr <= vec_addr + AW'(1);
          st       <= ST_RDB;
        end
        ST_RDB: begin
          vhi_q <= mem_rdata;
          st    <= ST_RDC;
        end
        ST_RDC: begin
          vlo_q <= mem_rdata;
          st    <= ST_PAD;
        end
        ST_PAD: begin
          if (cyc_q >= end_cyc) begin
            done   <= 1'b1;
            busy   <= 1'b0;
            s_out  <= sp_q;
            pc_out <= {vhi_q, vlo_q};
            cc_out <= (kind_q == K_TRAP1) ? (ctx_q.cc | MSK_SET) : ctx_q.cc;
            st     <= ST_IDLE;
          end
        end
        ST_HALT: begin
          if (wake) begin
            halted <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: stack writes walk downward one byte per cycle
  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - AW'(1));

  // R2: writes only happen inside a running sequence, never together with a read
  p_we_busy_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy && !mem_re);

  // R3: every completed save returns condition codes carrying the entire-state flag
  p_ent_flag_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> cc_out[CC_ENT]);

  // R5: the first trap kind leaves both interrupt masks set
  p_trap1_masks_r5: assert property (@(posedge clk) disable iff (rst)
    done && kind_q == K_TRAP1 |-> cc_out[CC_FMSK] && cc_out[CC_IMSK]);

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: halt persists until woken and never issues reads
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    halted && !wake |=> halted);
  p_halt_noread_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_re && !mem_we);

  // R8: a sequence in progress or a halt is not disturbed by start
  p_busy_halt_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy && halted));

endmodule

// File: tb/sim_ctx_stack_seq.sv
module sim_ctx_stack_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  kind = '0;
  logic [7:0]  mask_imm = '0, cc_in = '0, a_in = '0, b_in = '0, dp_in = '0;
  logic [15:0] x_in = '0, y_in = '0, u_in = '0, s_in = '0, pc_in = '0;
  logic        wake = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, cc_out;
  logic [15:0] s_out, pc_out;
  logic        busy, halted, done;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int cycles = 0;

  logic [7:0]  mem [0:65535];
  logic        tb_we = 1'b0;
  logic [15:0] tb_addr = '0;
  logic [7:0]  tb_data = '0;

  always #5 clk = ~clk;

  ctx_stack_seq u0 (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .mask_imm(mask_imm),
    .cc_in(cc_in), .a_in(a_in), .b_in(b_in), .dp_in(dp_in), .x_in(x_in),
    .y_in(y_in), .u_in(u_in), .s_in(s_in), .pc_in(pc_in), .wake(wake),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .cc_out(cc_out), .s_out(s_out),
    .pc_out(pc_out), .busy(busy), .halted(halted), .done(done)
  );

  // Memory model with a one-cycle synchronous read
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tb_we) mem[tb_addr] <= tb_data;
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_re) begin
      mem_rdata <= mem[mem_addr];
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = addr; tb_data = data;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [15:0] exp_vec(input logic [1:0] k);
    case (k)
      2'd1:    return 16'hFFF4;
      2'd2:    return 16'hFFF2;
      default: return 16'hFFFA;
    endcase
  endfunction

  function automatic logic [7:0] exp_stk_cc(input logic [1:0] k, input logic [7:0] cc,
                                            input logic [7:0] mk);
    return ((k == 2'd3) ? (cc & mk) : cc) | 8'h80;
  endfunction

  function automatic int exp_done_cyc(input logic [1:0] k);
    return (k == 2'd0) ? 19 : (k == 2'd3) ? 13 : 20;
  endfunction

  // Byte expected at s-12+i after the save
  function automatic logic [7:0] exp_img(input int i, input logic [7:0] scc);
    case (i)
      0:  return scc;
      1:  return a_in;
      2:  return b_in;
      3:  return dp_in;
      4:  return x_in[15:8];
      5:  return x_in[7:0];
      6:  return y_in[15:8];
      7:  return y_in[7:0];
      8:  return u_in[15:8];
      9:  return u_in[7:0];
      10: return pc_in[15:8];
      default: return pc_in[7:0];
    endcase
  endfunction

  task automatic run_op(input logic [1:0] k, input logic [7:0] cc, input logic [7:0] mk,
                        input logic [15:0] s, input bit dbl_start);
    int n;
    int w0;
    int r0;
    int bad;
    logic [15:0] v;
    logic [7:0] vh;
    logic [7:0] vl;
    logic [7:0] scc;
    logic [7:0] ecc;
    v  = exp_vec(k);
    vh = 8'($urandom);
    vl = 8'($urandom);
    poke(v, vh);
    poke(v + 16'd1, vl);
    @(negedge clk);
    w0 = wr_cnt; r0 = rd_cnt;
    kind = k; cc_in = cc; mask_imm = mk; s_in = s;
    a_in = 8'($urandom); b_in = 8'($urandom); dp_in = 8'($urandom);
    x_in = 16'($urandom); y_in = 16'($urandom); u_in = 16'($urandom);
    pc_in = 16'($urandom);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      start = (dbl_start && n == 5) ? 1'b1 : 1'b0;  // R8 pulse while busy
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    scc = exp_stk_cc(k, cc, mk);
    chk(n == exp_done_cyc(k), (k == 2'd3) ? "R7 done cycle" : "R6 done cycle",
        32'(n), 32'(exp_done_cyc(k)));
    chk(s_out == s - 16'd12, "R6 s_out", 32'(s_out), 32'(s - 16'd12));
    bad = 0;
    for (int i = 0; i < 12; i++)
      if (mem[16'(s - 16'd12 + 16'(i))] !== exp_img(i, scc)) bad++;
    chk(bad == 0, "R2 stack image", 32'(bad), 32'd0);
    chk(mem[16'(s - 16'd12)] == scc, "R3 stacked cc",
        32'(mem[16'(s - 16'd12)]), 32'(scc));
    if (k == 2'd3) begin
      chk(halted == 1'b1, "R7 halted", 32'(halted), 32'd1);
      chk(pc_out == pc_in, "R7 pc kept", 32'(pc_out), 32'(pc_in));
      chk(cc_out == scc, "R7 cc_out", 32'(cc_out), 32'(scc));
      chk(rd_cnt == r0, "R7 no reads", 32'(rd_cnt - r0), 32'd0);
    end else begin
      ecc = (k == 2'd0) ? (scc | 8'h50) : scc;
      chk(pc_out == {vh, vl}, "R4 pc vector", 32'(pc_out), 32'({vh, vl}));
      chk(cc_out == ecc, "R5 cc_out", 32'(cc_out), 32'(ecc));
      chk(rd_cnt - r0 == 2, "R4 read count", 32'(rd_cnt - r0), 32'd2);
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", 32'(done), 32'd0);
    chk(wr_cnt - w0 == 12, "R2 R8 write count", 32'(wr_cnt - w0), 32'd12);
    if (k == 2'd3) begin
      // R8: start while halted must not restart the save
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        if (done) n++;
      end
      chk(wr_cnt - w0 == 12 && n == 0, "R8 start ignored while halted",
          32'(wr_cnt - w0), 32'd12);
      chk(halted == 1'b1, "R7 halt held", 32'(halted), 32'd1);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      chk(halted == 1'b0, "R7 wake release", 32'(halted), 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h0BADC0DE));
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    mem_rdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    chk({busy, done, halted, mem_we, mem_re} == 5'b0, "R1 strobes in reset",
        32'({busy, done, halted, mem_we, mem_re}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(cc_out == 8'h00 && s_out == 16'h0 && pc_out == 16'h0, "R1 outputs after reset",
        32'({cc_out, pc_out}), 32'd0);
    chk(busy == 1'b0 && halted == 1'b0, "R1 idle after reset", 32'({busy, halted}), 32'd0);
    // Directed corners
    run_op(2'd0, 8'h00, 8'hFF, 16'h8000, 1'b0);
    run_op(2'd1, 8'h80, 8'hFF, 16'h000C, 1'b0);
    run_op(2'd2, 8'h2F, 8'h00, 16'hFF00, 1'b1);
    run_op(2'd3, 8'hFF, 8'hAF, 16'h4000, 1'b0);
    run_op(2'd3, 8'h7F, 8'h00, 16'h000C, 1'b0);
    run_op(2'd0, 8'hFF, 8'h00, 16'h1234, 1'b1);
    // Random mix
    for (int t = 0; t < 24; t++)
      run_op(2'($urandom), 8'($urandom), 8'($urandom),
             16'h1000 + 16'($urandom_range(0, 16'hDFFF)), 1'($urandom));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule